// File: doc/BRIEF.md
# Multichannel Oscillator Waveform Capture Buffer

This block records the raw logic levels of a bundle of free-running oscillator outputs. On every rising edge of its clock, during a capture, it writes the whole input word into one row of an on-chip memory. Bit column c of the memory therefore holds the sampled waveform of channel c. The clock may be a board reference in absolute mode, or the output of a longer on-chip ring oscillator in differential mode. The logic is the same in both modes. The inputs are latched exactly as they arrive: there is no edge detection and no filtering.

A one-cycle arm pulse starts a capture at row zero. The block stays busy until the last row has been written, then raises a done flag. A processor-side read port returns stored rows while no capture is running. A read attempted during a capture is refused: it returns zero and raises an error flag, and the write sequence is not disturbed.

Top module: `osc_cap_buffer`

## Requirements
- R1: After reset, busy, done, rd_valid and rd_err are low and rd_data is zero.
- R2: When arm is high while idle or done, busy rises on the next cycle. It then stays high for exactly 2^ADDR_W clock cycles (1024 by default) and then falls.
- R3: done rises in the same cycle that busy falls. It stays high until a new arm is accepted, and it is low in the cycle after that arm.
- R4: Row k holds the input word sampled at the (k+1)-th rising edge after the arm edge. Channel c is stored in bit c of the row, for every k from 0 to 2^ADDR_W-1.
- R5: Stored bits are the raw levels present at each sampling edge. An input that toggles on every cycle is stored as an alternating column, with no filtering.
- R6: An arm pulse during a capture has no effect. busy still falls 2^ADDR_W cycles after the original arm, and every row holds the original sequence.
- R7: A read request while not busy gives the row at rd_addr on rd_data one cycle later, with rd_valid high for that cycle and rd_err low.
- R8: A read request while busy gives rd_data equal to zero one cycle later, with rd_err high and rd_valid low for that cycle. The capture is not disturbed.
- R9: While rd_en is low, rd_data keeps its last value.
- R10: A new capture overwrites every row, so a readback after it returns only the new data.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock (reference or ring oscillator) |
| rst | input | 1 | Synchronous active-high reset |
| arm | input | 1 | One-cycle pulse that starts a capture |
| osc_in | input | CHANNELS | Raw oscillator outputs, one bit per channel |
| busy | output | 1 | Capture in progress |
| done | output | 1 | Capture complete, held until the next arm |
| rd_en | input | 1 | Read request from the processor side |
| rd_addr | input | ADDR_W | Row to read |
| rd_data | output | CHANNELS | Registered read data |
| rd_valid | output | 1 | rd_data holds an accepted read |
| rd_err | output | 1 | Last read request was refused during a capture |

## Verification
The hardest case to reach from the ports is a read request or a second arm pulse that lands in the middle of a capture. Both must leave the write sequence untouched, and that can only be seen after the capture has ended. The bench therefore injects a read at row 100 and a stray arm at row 200 while it is driving a known per-cycle pattern. It then reads back every row and compares it with the pattern. It also checks that busy lasted exactly the full depth even though the stray arm arrived partway through.

// File: rtl/osc_cap_pkg.sv
package osc_cap_pkg;
  typedef enum logic [1:0] {
    CAP_IDLE = 2'd0,
    CAP_RUN  = 2'd1,
    CAP_FULL = 2'd2
  } cap_state_t;
endpackage

// File: rtl/osc_cap_ctrl.sv
module osc_cap_ctrl
  import osc_cap_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              arm,
  output logic              busy,
  output logic              done,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr
);
  localparam logic [ADDR_W-1:0] LAST_ROW = {ADDR_W{1'b1}};

  cap_state_t        state_q;
  logic [ADDR_W-1:0] addr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= CAP_IDLE;
      addr_q  <= '0;
    end else begin
      case (state_q)
        CAP_RUN: begin
          if (addr_q == LAST_ROW) begin
            state_q <= CAP_FULL;
            addr_q  <= '0;
          end else begin
            addr_q <= addr_q + ADDR_W'(1);
          end
        end
        default: begin
          if (arm) begin
            state_q <= CAP_RUN;
            addr_q  <= '0;
          end
        end
      endcase
    end
  end

  assign busy    = (state_q == CAP_RUN);
  assign done    = (state_q == CAP_FULL);
  assign wr_en   = busy;
  assign wr_addr = addr_q;

  // R2
  start_chk: assert property (@(posedge clk) disable iff (rst)
    (arm && !busy) |=> (busy && wr_addr == '0));
  // R2
  end_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && wr_addr == LAST_ROW) |=> (!busy && done));
  // R6
  step_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && wr_addr != LAST_ROW) |=> (busy && wr_addr == $past(wr_addr) + ADDR_W'(1)));
  // R3
  done_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (done && !arm) |=> done);
  // R3
  excl_chk: assert property (@(posedge clk) disable iff (rst) !(done && busy));
endmodule

// File: rtl/osc_cap_rdport.sv
module osc_cap_rdport (
  input  logic clk,
  input  logic rst,
  input  logic rd_en,
  input  logic busy,
  output logic ram_re,
  output logic ram_zero,
  output logic rd_valid,
  output logic rd_err
);
  assign ram_re   = rd_en;
  assign ram_zero = busy;

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid <= 1'b0;
      rd_err   <= 1'b0;
    end else begin
      rd_valid <= rd_en && !busy;
      rd_err   <= rd_en && busy;
    end
  end

  // R7
  accept_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_en && !busy) |=> (rd_valid && !rd_err));
  // R8
  refuse_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_en && busy) |=> (rd_err && !rd_valid));
endmodule

// File: rtl/osc_cap_mem.sv
module osc_cap_mem #(
  parameter int WIDTH  = 18,
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [WIDTH-1:0]  wdata,
  input  logic              re,
  input  logic              rzero,
  input  logic [ADDR_W-1:0] raddr,
  output logic [WIDTH-1:0]  rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [WIDTH-1:0] rows [DEPTH];

  always_ff @(posedge clk) begin
    if (we) rows[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else if (re) begin
      rdata <= rzero ? '0 : rows[raddr];
    end
  end

  // R8
  zero_chk: assert property (@(posedge clk) disable iff (rst)
    (re && rzero) |=> (rdata == '0));
  // R9
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    !re |=> $stable(rdata));
endmodule

// File: rtl/osc_cap_buffer.sv
module osc_cap_buffer #(
  parameter int CHANNELS = 18,
  parameter int ADDR_W   = 10
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                arm,
  input  logic [CHANNELS-1:0] osc_in,
  output logic                busy,
  output logic                done,
  input  logic                rd_en,
  input  logic [ADDR_W-1:0]   rd_addr,
  output logic [CHANNELS-1:0] rd_data,
  output logic                rd_valid,
  output logic                rd_err
);
  logic                wr_en;
  logic [ADDR_W-1:0]   wr_addr;
  logic [CHANNELS-1:0] sample_word;
  logic                ram_re;
  logic                ram_zero;

  // channel c goes to column c, raw level, no conditioning (R4, R5)
  for (genvar c = 0; c < CHANNELS; c++) begin : g_pack
    assign sample_word[c] = osc_in[c];
  end

  osc_cap_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rst(rst), .arm(arm), .busy(busy), .done(done),
    .wr_en(wr_en), .wr_addr(wr_addr)
  );

  osc_cap_rdport u_rdport (
    .clk(clk), .rst(rst), .rd_en(rd_en), .busy(busy),
    .ram_re(ram_re), .ram_zero(ram_zero), .rd_valid(rd_valid), .rd_err(rd_err)
  );

  osc_cap_mem #(.WIDTH(CHANNELS), .ADDR_W(ADDR_W)) u_mem (
    .clk(clk), .rst(rst), .we(wr_en), .waddr(wr_addr), .wdata(sample_word),
    .re(ram_re), .rzero(ram_zero), .raddr(rd_addr), .rdata(rd_data)
  );

  // R1
  reset_chk: assert property (@(posedge clk)
    rst |=> (!busy && !done && !rd_valid && !rd_err && rd_data == '0));
endmodule

// File: tb/osc_cap_buffer_bench.sv
module osc_cap_buffer_bench;
  localparam int CH    = 18;
  localparam int AW    = 10;
  localparam int DEPTH = 1 << AW;

  // vector table: {mode, seed}; mode 0 const, 1 toggle each cycle, 2 counter xor, 3 per-channel divider
  localparam logic [1+CH:0] VEC [4] = '{
    {2'd0, 18'h2A5C3},
    {2'd1, 18'h15555},
    {2'd2, 18'h3F00F},
    {2'd3, 18'h0C0C3}
  };

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          arm = 1'b0;
  logic [CH-1:0] osc_in = '0;
  logic          busy, done, rd_valid, rd_err;
  logic          rd_en = 1'b0;
  logic [AW-1:0] rd_addr = '0;
  logic [CH-1:0] rd_data;

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  osc_cap_buffer #(.CHANNELS(CH), .ADDR_W(AW)) u_osc_cap_buffer (
    .clk(clk), .rst(rst), .arm(arm), .osc_in(osc_in), .busy(busy), .done(done),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .rd_valid(rd_valid), .rd_err(rd_err)
  );

  function automatic logic [CH-1:0] pat(input logic [1:0] mode, input logic [CH-1:0] seed, input int k);
    logic [CH-1:0] w;
    case (mode)
      2'd0: w = seed;
      2'd1: w = k[0] ? ~seed : seed;
      2'd2: w = CH'(k) ^ seed;
      default: begin
        for (int c = 0; c < CH; c++) w[c] = ((k >> (c % 5)) & 1) != 0 ? ~seed[c] : seed[c];
      end
    endcase
    return w;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // one full capture; optional stray read (R8) and stray arm (R6) mid-way
  task automatic capture(input logic [1:0] mode, input logic [CH-1:0] seed, input bit disturb);
    int busy_cnt = 0;
    @(negedge clk) arm = 1'b1;
    @(negedge clk) arm = 1'b0;
    chk(!done, "R3 done cleared after arm", done, 0);
    for (int k = 0; k < DEPTH; k++) begin
      if (k > 0) @(negedge clk);
      if (busy) busy_cnt++;
      osc_in = pat(mode, seed, k);
      if (disturb && k == 100) begin rd_en = 1'b1; rd_addr = AW'(5); end
      if (disturb && k == 101) begin
        rd_en = 1'b0;
        chk(rd_err && !rd_valid && rd_data == '0, "R8 refused read", {rd_err, rd_valid, rd_data}, {2'b10, {CH{1'b0}}});
      end
      if (disturb && k == 200) arm = 1'b1;
      if (disturb && k == 201) arm = 1'b0;
    end
    @(negedge clk);
    chk(busy_cnt == DEPTH, disturb ? "R6 R2 busy length" : "R2 busy length", busy_cnt, DEPTH);
    chk(!busy && done, "R3 done at end", {busy, done}, 2'b01);
  endtask

  task automatic read_row(input int a, output logic [CH-1:0] d, output logic v, output logic e);
    @(negedge clk) begin rd_en = 1'b1; rd_addr = AW'(a); end
    @(negedge clk) rd_en = 1'b0;
    d = rd_data; v = rd_valid; e = rd_err;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [CH-1:0] d, held;
    logic v, e;
    int bad;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1
    chk(!busy && !done && !rd_valid && !rd_err && rd_data == '0, "R1 reset state",
        {busy, done, rd_valid, rd_err, rd_data}, 0);

    for (int i = 0; i < 4; i++) begin
      logic [1:0] mode;
      logic [CH-1:0] seed;
      mode = VEC[i][1+CH:CH];
      seed = VEC[i][CH-1:0];
      capture(mode, seed, i == 2);
      bad = 0;
      for (int k = 0; k < DEPTH; k++) begin
        read_row(k, d, v, e);
        if (d !== pat(mode, seed, k) || !v || e) begin
          bad++;
          if (bad == 1) $display("FAIL R4 R10 row %0d actual=%0h expected=%0h", k, d, pat(mode, seed, k));
        end
      end
      // R4 R5 R10 (mode 1 = per-cycle toggle for R5); R7 valid on each read
      chk(bad == 0, mode == 2'd1 ? "R5 R4 raw toggle rows" : "R4 R7 R10 rows", bad, 0);
    end

    // R9 hold without request
    held = rd_data;
    repeat (4) @(negedge clk);
    chk(rd_data == held, "R9 rd_data hold", rd_data, held);
    chk(!rd_valid && !rd_err, "R7 rd_valid single cycle", {rd_valid, rd_err}, 0);
    // R3 done held while idle
    chk(done, "R3 done held", done, 1);
    // R7 last-row boundary, first-row boundary
    read_row(DEPTH - 1, d, v, e);
    chk(d == pat(2'd3, 18'h0C0C3, DEPTH - 1) && v && !e, "R7 last row", d, pat(2'd3, 18'h0C0C3, DEPTH - 1));
    read_row(0, d, v, e);
    chk(d == pat(2'd3, 18'h0C0C3, 0) && v && !e, "R7 first row", d, pat(2'd3, 18'h0C0C3, 0));
    // R1 reset mid-capture
    @(negedge clk) arm = 1'b1;
    @(negedge clk) arm = 1'b0;
    repeat (5) @(negedge clk);
    rst = 1'b1;
    @(negedge clk) rst = 1'b0;
    chk(!busy && !done && rd_data == '0, "R1 reset during capture", {busy, done, rd_data}, 0);

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule